// File: doc/BRIEF.md
# SWD Link Activation Sequencer

This block sits on the host side of a Serial Wire Debug link and brings a debug port from an unknown line state into SWD operation before any transaction is issued. On a start request it drives a fixed bit stream onto SWDIO while generating SWCLK from the system clock through a programmable divider. Three streams are available:

- **Dormant wake-up:** a 128-bit selection alert, four idle-low cycles and the activation code, then a line reset.
- **Legacy switch:** 64 high bits and the 16-bit switch code, then a line reset.
- **Line reset only.**

All three streams end in the same shared line-reset segment. One clean reset pattern exists in the design, and every path reaches it.

The host logic raises `start` for one or more system cycles. It selects the stream with `legacy_mode` and `reset_only`, which are captured with the start. It then waits for the single-cycle `done` pulse. Outside a sequence the block releases SWDIO (`swdio_oe` low) and parks SWCLK low, so a transaction engine can take the pins over.

Top module: `swd_wake_seq`

## Requirements
- R1: Every segment word is shifted onto `swdio_out` least significant bit first, one bit per SWCLK period. `swdio_out` changes only while SWCLK is low and is stable throughout every SWCLK high phase.
- R2: With `legacy_mode`=0 and `reset_only`=0, the stream is 204 bits long, in this order:
  - the alert words 0x6209F392, 0x86852D95, 0xE3DDAFE9 and 0x19BC0EA2, in that order;
  - the 12-bit field 0x1A0 (four low bits, then activation code 0x1A);
  - a line reset.
- R3: A line reset is 32 ones followed by the word 0x0FFFFFFF, giving 60 high bits and then 4 low bits.
- R4: With `legacy_mode`=1 and `reset_only`=0, the stream is 144 bits long, in this order:
  - 64 ones;
  - the 16-bit code 0xE79E;
  - a line reset.
- R5: With `reset_only`=1, the stream is a single 64-bit line reset, whatever the value of `legacy_mode`.
- R6: SWCLK high and low phases each last max(`clk_div`,1) system clock cycles. The first phase of a sequence is low.
- R7: `swdio_oe` is high from the cycle after an accepted start until the last bit's falling SWCLK edge, and is high whenever SWCLK is high.
- R8: `done` is high for exactly one system cycle, in the cycle after the final falling SWCLK edge. In that cycle SWCLK is low and `swdio_oe` is low.
- R9: A start request arriving while a sequence runs has no effect: the stream, its length and its mode are those of the original request.
- R10: After reset, and whenever idle, `swclk`, `swdio_out`, `swdio_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence when idle |
| legacy_mode | input | 1 | 1 selects the legacy switch stream, 0 the dormant wake-up |
| reset_only | input | 1 | 1 sends a line reset alone (overrides legacy_mode) |
| clk_div | input | DIV_W (8) | SWCLK half-period in system cycles; 0 acts as 1 |
| swclk | output | 1 | Serial wire clock |
| swdio_out | output | 1 | Serial wire data driven by the host |
| swdio_oe | output | 1 | Output enable for SWDIO |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default 8-bit divider field and sweeps `clk_div` over 0, 1, 2 and 3. This puts the zero-means-one corner and both even and odd half-periods within reach in runs of a few thousand cycles.

Every combination of the two mode bits is run at every divider value. The captured SWDIO bits are compared one by one against streams assembled arithmetically from the segment words. This exposes:
- any ordering, bit-order or segment-boundary fault;
- the override of `reset_only` over `legacy_mode`.

Extra runs inject a second start, with a different mode, in the middle of a sequence.

// File: rtl/swd_wake_pkg.sv
package swd_wake_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int SEG_W  = 3;

  typedef enum logic [1:0] {
    SEQ_DORMANT = 2'd0,
    SEQ_LEGACY  = 2'd1,
    SEQ_LRESET  = 2'd2
  } seq_mode_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [LEN_W-1:0]  len_m1;
  } seg_t;

  // shared two-segment line reset tail
  function automatic seg_t lreset_seg(input logic sub);
    seg_t s;
    s.len_m1 = LEN_W'(WORD_W - 1);
    s.word   = sub ? 32'h0FFF_FFFF : 32'hFFFF_FFFF;
    return s;
  endfunction

  function automatic logic [SEG_W-1:0] seg_count(input seq_mode_t m);
    case (m)
      SEQ_DORMANT: return SEG_W'(7);
      SEQ_LEGACY:  return SEG_W'(5);
      default:     return SEG_W'(2);
    endcase
  endfunction

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             swclk,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_eff;
  logic             wrap;

  assign half_eff = (half == '0) ? DIV_W'(1) : half;
  assign wrap     = (cnt_q == half_eff - DIV_W'(1));
  assign fall     = run && wrap && swclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      swclk <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      swclk <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      swclk <= ~swclk;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/swd_seg_table.sv
module swd_seg_table
  import swd_wake_pkg::*;
(
  input  seq_mode_t        mode,
  input  logic [SEG_W-1:0] idx,
  output seg_t             seg
);
  localparam int TAIL_DORM = 5;
  localparam int TAIL_LEG  = 3;

  always_comb begin
    seg.word   = '1;
    seg.len_m1 = LEN_W'(WORD_W - 1);
    case (mode)
      SEQ_DORMANT: begin
        case (idx)
          3'd0: seg.word = 32'h6209_F392;
          3'd1: seg.word = 32'h8685_2D95;
          3'd2: seg.word = 32'hE3DD_AFE9;
          3'd3: seg.word = 32'h19BC_0EA2;
          3'd4: begin
            seg.word   = 32'h0000_01A0;
            seg.len_m1 = LEN_W'(11);
          end
          default: seg = lreset_seg(idx == SEG_W'(TAIL_DORM + 1));
        endcase
      end
      SEQ_LEGACY: begin
        case (idx)
          3'd0, 3'd1: seg.word = 32'hFFFF_FFFF;
          3'd2: begin
            seg.word   = 32'h0000_E79E;
            seg.len_m1 = LEN_W'(15);
          end
          default: seg = lreset_seg(idx == SEG_W'(TAIL_LEG + 1));
        endcase
      end
      default: seg = lreset_seg(idx == SEG_W'(1));
    endcase
  end
endmodule

// File: rtl/swd_bit_shifter.sv
module swd_bit_shifter
  import swd_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len_m1,
  output logic              bit_o,
  output logic              seg_end
);
  logic [WORD_W-1:0] sh_q;
  logic [LEN_W-1:0]  rem_q;

  assign bit_o   = sh_q[0];
  assign seg_end = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= word;
      rem_q <= len_m1;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
      rem_q <= rem_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/swd_wake_seq.sv
module swd_wake_seq
  import swd_wake_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             legacy_mode,
  input  logic             reset_only,
  input  logic [DIV_W-1:0] clk_div,
  output logic             swclk,
  output logic             swdio_out,
  output logic             swdio_oe,
  output logic             done
);
  logic             busy_q;
  logic             done_q;
  seq_mode_t        mode_q;
  seq_mode_t        mode_in;
  seq_mode_t        mode_sel;
  logic [SEG_W-1:0] seg_q;
  logic [SEG_W-1:0] seg_sel;
  seg_t             seg;
  logic             fall;
  logic             bit_o;
  logic             seg_end;
  logic             accept;
  logic             last_seg;
  logic             do_load;
  logic             do_shift;

  assign mode_in  = reset_only ? SEQ_LRESET : (legacy_mode ? SEQ_LEGACY : SEQ_DORMANT);
  assign accept   = start && !busy_q;
  assign last_seg = (seg_q == seg_count(mode_q) - SEG_W'(1));
  assign mode_sel = busy_q ? mode_q : mode_in;
  assign seg_sel  = busy_q ? seg_q + SEG_W'(1) : '0;
  assign do_load  = accept || (busy_q && fall && seg_end && !last_seg);
  assign do_shift = busy_q && fall && !seg_end;

  swd_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .half  (clk_div),
    .swclk (swclk),
    .fall  (fall)
  );

  swd_seg_table u_tab (
    .mode (mode_sel),
    .idx  (seg_sel),
    .seg  (seg)
  );

  swd_bit_shifter u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_load),
    .shift   (do_shift),
    .word    (seg.word),
    .len_m1  (seg.len_m1),
    .bit_o   (bit_o),
    .seg_end (seg_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= SEQ_DORMANT;
      seg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= mode_in;
        seg_q  <= '0;
      end else if (busy_q && fall && seg_end) begin
        if (last_seg) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          seg_q <= seg_q + SEG_W'(1);
        end
      end
    end
  end

  assign swdio_out = busy_q & bit_o;
  assign swdio_oe  = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/swd_wake_seq_chk.sv
module swd_wake_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic swclk,
  input logic swdio_out,
  input logic swdio_oe,
  input logic done
);
  // R1
  data_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> $stable(swdio_out));

  // R7
  oe_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> swdio_oe);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!swclk && !swdio_oe && $past(swdio_oe)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swdio_oe |-> (!swdio_out && !swclk));
endmodule

bind swd_wake_seq swd_wake_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .swclk     (swclk),
  .swdio_out (swdio_out),
  .swdio_oe  (swdio_oe),
  .done      (done)
);

// File: tb/sim_swd_wake_seq.sv
`timescale 1ns/1ps
module sim_swd_wake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       legacy_mode = 1'b0;
  logic       reset_only = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic       swclk, swdio_out, swdio_oe, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  bit exp_bits [0:255];
  int exp_len;
  bit got_bits [0:255];
  int got_len;
  int per_bad;
  int oe_bad;
  int done_cnt;
  int last_rise;
  logic prev_clk;

  always #2 clk = ~clk;

  swd_wake_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .legacy_mode(legacy_mode),
    .reset_only(reset_only), .clk_div(clk_div), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] w, input int len);
    for (int i = 0; i < len; i++) begin
      exp_bits[exp_len] = w[i];
      exp_len++;
    end
  endtask

  task automatic push_lreset();  // R3
    push(32'hFFFF_FFFF, 32);
    push(32'h0FFF_FFFF, 32);
  endtask

  task automatic build(input bit leg, input bit ro);
    exp_len = 0;
    if (ro) begin
      push_lreset();
    end else if (leg) begin  // R4
      push(32'hFFFF_FFFF, 32);
      push(32'hFFFF_FFFF, 32);
      push(32'h0000_E79E, 16);
      push_lreset();
    end else begin  // R2
      push(32'h6209_F392, 32);
      push(32'h8685_2D95, 32);
      push(32'hE3DD_AFE9, 32);
      push(32'h19BC_0EA2, 32);
      push(32'h0000_01A0, 12);
      push_lreset();
    end
  endtask

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (swclk && !prev_clk) begin
      if (got_len < 256) got_bits[got_len] = swdio_out;
      if (got_len > 0 && (cyc - last_rise) != 2 * ((clk_div == 0) ? 1 : int'(clk_div)))
        per_bad++;
      last_rise = cyc;
      got_len++;
    end
    if (swclk && !swdio_oe) oe_bad++;
    if (done) done_cnt++;
    prev_clk = swclk;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run(input bit leg, input bit ro, input int div, input bit poke);
    int first_bad;
    int t;
    string tag;
    tag = ro ? "R5" : (leg ? "R4" : "R2");
    clk_div = 8'(div);
    build(leg, ro);
    got_len = 0; per_bad = 0; oe_bad = 0; done_cnt = 0;
    @(negedge clk);
    legacy_mode = leg; reset_only = ro; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(swdio_oe && !swclk, "R6 R7 first phase low, oe high", {30'd0, swdio_oe, swclk}, 2);
    legacy_mode = ~leg; reset_only = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 37) begin
        start = 1'b1; reset_only = ~ro;
      end
      if (poke && t == 39) start = 1'b0;
    end
    check(!swclk && !swdio_oe && !swdio_out, "R8 R10 idle at done", {29'd0, swclk, swdio_oe, swdio_out}, 0);
    @(negedge clk);
    check(done_cnt == 1 && !done, "R8 done width", done_cnt, 1);
    check(got_len == exp_len, poke ? "R9 length" : {tag, " length"}, got_len, exp_len);
    first_bad = -1;
    for (int i = 0; i < exp_len && i < got_len; i++)
      if (got_bits[i] != exp_bits[i] && first_bad < 0) first_bad = i;
    check(first_bad < 0, poke ? "R9 R1 stream" : {tag, " R1 R3 stream"}, first_bad, -1);
    check(per_bad == 0, "R6 half-period", per_bad, 0);
    check(oe_bad == 0, "R7 oe during clock", oe_bad, 0);
    reset_only = 1'b0; legacy_mode = 1'b0;
    repeat (5) @(negedge clk);
    check(!swclk && !swdio_oe && !done, "R10 stays idle", {29'd0, swclk, swdio_oe, done}, 0);
  endtask

  initial begin
    prev_clk = 1'b0;
    last_rise = 0;
    got_len = 0;
    repeat (3) @(negedge clk);
    check(!swclk && !swdio_out && !swdio_oe && !done, "R10 reset state",
          {28'd0, swclk, swdio_out, swdio_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 4; m++)
        run(m[0], m[1], d, 1'b0);
    run(1'b0, 1'b0, 2, 1'b1);
    run(1'b1, 1'b0, 1, 1'b1);
    run(1'b0, 1'b1, 3, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule